// File: doc/BRIEF.md
# Miss Response Counting Tracker

This block follows one outstanding cache miss from the moment its read or write request goes out until every owed response has come back. On allocation it preloads a signed pending count with the number of caches in the system: each other cache owes one response and memory owes one. Each arriving response removes as many units as it carries. Two single-step inputs nudge the count by one in either direction. These cover an upgrade from an owned line, which needs one message fewer, and an upgrade that loses ownership to another writer, which needs one message more.

When an update lands the count exactly on zero, the tracker raises a one-cycle completion pulse. The pulse carries a kind bit that says whether any response since allocation reported another sharer. The tracker also keeps the identity of the latest responder and the time of the first response. It adopts request and forward timestamps carried by responses, but only when those values are nonzero. Any illegal update sets a sticky error flag and leaves the count untouched. Such updates are a zero-ack response and any step that would leave the count's legal range. Deallocation wipes every field.

Top module: `miss_ack_tracker`

## Requirements
- R1: Out of reset the tracker is inactive and every output reads zero: pending count, error, sharers, completion pulse, completion kind, last responder and all three timestamps.
- R2: An allocate pulse makes the tracker active and loads the pending count with NUM_CACHES. In the same step it clears the sharers flag, the error flag, the completion state, the responder and all timestamps.
- R3: While the tracker is active, a valid response subtracts its ack field from the pending count. A response whose ack field is zero sets the error flag and subtracts nothing.
- R4: A valid response with its shared bit at 1 sets a sharers flag, which stays set until the next allocate or deallocate.
- R5: When an active-cycle update leaves the count at exactly zero, done_o is 1 for exactly the following cycle. Its kind bit done_shared_o is 1 if the sharers flag (including the completing response's own shared bit) is set, and 0 otherwise. The pulse fires at most once per allocation.
- R6: The decrement pulse subtracts one and the increment pulse adds one. Both pulses can coincide with each other and with a response, and their effects add up.
- R7: An update whose result would fall below zero or above 2^(CNT_W-1)-1 leaves the count unchanged and sets the sticky error flag. CNT_W defaults to clog2(2*NUM_CACHES)+2.
- R8: Every valid response while the tracker is active stores its sender ID as the last responder.
- R9: The first-response time takes the value of now_i on a valid response only while it still reads zero. The request and forward timestamps take a response's values only when those values are nonzero.
- R10: A deallocate pulse clears every field and makes the tracker inactive. It has priority over a simultaneous allocate.
- R11: While the tracker is inactive, responses and adjust pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Allocate and preload for a new miss |
| dealloc_i | input | 1 | Clear all state |
| rsp_valid_i | input | 1 | Response present this cycle |
| rsp_acks_i | input | ACK_W | Units carried by the response |
| rsp_shared_i | input | 1 | Responder holds a shared copy |
| rsp_sender_i | input | ID_W | Responder identity |
| rsp_req_time_i | input | TIME_W | Request timestamp in the response, 0 = absent |
| rsp_fwd_time_i | input | TIME_W | Forward timestamp in the response, 0 = absent |
| now_i | input | TIME_W | Current time |
| dec_one_i | input | 1 | Subtract one from the count |
| inc_one_i | input | 1 | Add one to the count |
| active_o | output | 1 | Tracker allocated |
| pending_o | output | CNT_W | Signed pending count |
| err_o | output | 1 | Sticky illegal-update flag |
| sharers_o | output | 1 | Sticky sharer-seen flag |
| done_o | output | 1 | One-cycle completion pulse |
| done_shared_o | output | 1 | Completion kind: 1 = sharer seen |
| last_sender_o | output | ID_W | Most recent responder |
| first_time_o | output | TIME_W | First-response time |
| req_time_o | output | TIME_W | Adopted request timestamp |
| fwd_time_o | output | TIME_W | Adopted forward timestamp |

## Verification
The checker watches several properties on every cycle. It checks the preload value after allocation and the total wipe after deallocation. It checks that the error and sharers flags stay set, that the completion pulse lasts one cycle and coincides with a zero count, and that the first-response time is frozen once nonzero. It also checks that an inactive tracker's count stays put. Several behaviours need the bench's scenarios instead: the arithmetic across every ack split of a miss, the combined effect of pulses arriving together with a response, the exact range bounds that trigger the error, the at-most-once rule after the count wanders back to zero, and the nonzero-only timestamp adoption.

// File: rtl/mat_pkg.sv
package mat_pkg;

   // Smallest signed width that holds twice the cache count
   function automatic int min_cnt_w(input int n);
      return $clog2(2 * n) + 2;
   endfunction

   typedef enum logic {
      CMPL_ALONE  = 1'b0,
      CMPL_SHARED = 1'b1
   } cmpl_kind_e;

endpackage

// File: rtl/mat_count.sv
module mat_count #(
   parameter int NUM_CACHES = 4,
   parameter int ACK_W      = 3,
   parameter int CNT_W      = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    load,
   input  logic                    en,
   input  logic                    rsp_v,
   input  logic [ACK_W-1:0]        acks,
   input  logic                    dec,
   input  logic                    inc,
   output logic signed [CNT_W-1:0] cnt,
   output logic                    err,
   output logic                    hit_zero
);
   localparam int EXT_W   = CNT_W + ACK_W + 1;
   localparam int CNT_MAX = (1 << (CNT_W - 1)) - 1;

   logic signed [CNT_W-1:0] cnt_q;
   logic                    err_q;
   logic signed [EXT_W-1:0] base_s, sub_s, adj_s, nxt_s;
   logic                    touched, in_range, zero_ack;

   always_comb begin
      base_s   = EXT_W'(cnt_q);
      sub_s    = rsp_v ? $signed({{(EXT_W-ACK_W){1'b0}}, acks}) : '0;
      adj_s    = $signed(EXT_W'(inc)) - $signed(EXT_W'(dec));
      nxt_s    = base_s - sub_s + adj_s;
      touched  = rsp_v | dec | inc;
      in_range = (nxt_s >= 0) && (nxt_s <= EXT_W'(CNT_MAX));
      zero_ack = rsp_v && (acks == '0);
      hit_zero = en && !clr && !load && touched && in_range && (nxt_s == 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (load) begin
         cnt_q <= CNT_W'(NUM_CACHES);
         err_q <= 1'b0;
      end else if (en && touched) begin
         if (in_range) cnt_q <= CNT_W'(nxt_s);
         if (!in_range || zero_ack) err_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign err = err_q;
endmodule

// File: rtl/mat_stamps.sv
module mat_stamps #(
   parameter int ID_W   = 4,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              en,
   input  logic              rsp_v,
   input  logic              shared,
   input  logic [ID_W-1:0]   sender,
   input  logic [TIME_W-1:0] req_t,
   input  logic [TIME_W-1:0] fwd_t,
   input  logic [TIME_W-1:0] now,
   output logic              sharers,
   output logic              sharers_nxt,
   output logic [ID_W-1:0]   last_sender,
   output logic [TIME_W-1:0] first_t,
   output logic [TIME_W-1:0] req_q_o,
   output logic [TIME_W-1:0] fwd_q_o
);
   localparam int N_ADOPT = 2;

   logic              take;
   logic              sh_q;
   logic [ID_W-1:0]   last_q;
   logic [TIME_W-1:0] first_q;
   logic [TIME_W-1:0] adopt_in [N_ADOPT];

   assign take        = en && rsp_v && !clr && !load;
   assign sharers_nxt = sh_q | (take & shared);
   assign adopt_in[0] = req_t;
   assign adopt_in[1] = fwd_t;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || load) begin
         sh_q    <= 1'b0;
         last_q  <= '0;
         first_q <= '0;
      end else if (take) begin
         sh_q   <= sh_q | shared;
         last_q <= sender;
         if (first_q == '0) first_q <= now;
      end
   end

   for (genvar g = 0; g < N_ADOPT; g++) begin : g_adopt
      logic [TIME_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr || load) q <= '0;
         else if (take && adopt_in[g] != '0) q <= adopt_in[g];
      end
   end

   assign sharers     = sh_q;
   assign last_sender = last_q;
   assign first_t     = first_q;
   assign req_q_o     = g_adopt[0].q;
   assign fwd_q_o     = g_adopt[1].q;
endmodule

// File: rtl/mat_trigger.sv
module mat_trigger
   import mat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   input  logic hit,
   input  logic sh_nxt,
   output logic done,
   output logic done_kind
);
   logic       fired_q, done_q;
   cmpl_kind_e kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || load) begin
         fired_q <= 1'b0;
         done_q  <= 1'b0;
         kind_q  <= CMPL_ALONE;
      end else if (hit && !fired_q) begin
         fired_q <= 1'b1;
         done_q  <= 1'b1;
         kind_q  <= sh_nxt ? CMPL_SHARED : CMPL_ALONE;
      end else begin
         done_q  <= 1'b0;
      end
   end

   assign done      = done_q;
   assign done_kind = (kind_q == CMPL_SHARED);
endmodule

// File: rtl/miss_ack_tracker.sv
module miss_ack_tracker #(
   parameter int NUM_CACHES = 4,
   parameter int ACK_W      = 3,
   parameter int ID_W       = 4,
   parameter int TIME_W     = 16,
   parameter int CNT_W      = mat_pkg::min_cnt_w(NUM_CACHES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_i,
   input  logic                    dealloc_i,
   input  logic                    rsp_valid_i,
   input  logic [ACK_W-1:0]        rsp_acks_i,
   input  logic                    rsp_shared_i,
   input  logic [ID_W-1:0]         rsp_sender_i,
   input  logic [TIME_W-1:0]       rsp_req_time_i,
   input  logic [TIME_W-1:0]       rsp_fwd_time_i,
   input  logic [TIME_W-1:0]       now_i,
   input  logic                    dec_one_i,
   input  logic                    inc_one_i,
   output logic                    active_o,
   output logic signed [CNT_W-1:0] pending_o,
   output logic                    err_o,
   output logic                    sharers_o,
   output logic                    done_o,
   output logic                    done_shared_o,
   output logic [ID_W-1:0]         last_sender_o,
   output logic [TIME_W-1:0]       first_time_o,
   output logic [TIME_W-1:0]       req_time_o,
   output logic [TIME_W-1:0]       fwd_time_o
);
   if (NUM_CACHES < 2) begin : g_bad_caches
      $error("NUM_CACHES must be at least 2");
   end
   if (CNT_W < mat_pkg::min_cnt_w(NUM_CACHES)) begin : g_bad_cnt
      $error("CNT_W too narrow for twice NUM_CACHES");
   end
   if (ACK_W < 1 || ID_W < 1 || TIME_W < 1) begin : g_bad_widths
      $error("field widths must be positive");
   end

   logic active_q;
   logic hit_zero, sh_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n || dealloc_i) active_q <= 1'b0;
      else if (alloc_i)        active_q <= 1'b1;
   end

   mat_count #(.NUM_CACHES(NUM_CACHES), .ACK_W(ACK_W), .CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(dealloc_i), .load(alloc_i), .en(active_q),
      .rsp_v(rsp_valid_i), .acks(rsp_acks_i), .dec(dec_one_i), .inc(inc_one_i),
      .cnt(pending_o), .err(err_o), .hit_zero(hit_zero)
   );

   mat_stamps #(.ID_W(ID_W), .TIME_W(TIME_W)) u_stamps (
      .clk(clk), .rst_n(rst_n), .clr(dealloc_i), .load(alloc_i), .en(active_q),
      .rsp_v(rsp_valid_i), .shared(rsp_shared_i), .sender(rsp_sender_i),
      .req_t(rsp_req_time_i), .fwd_t(rsp_fwd_time_i), .now(now_i),
      .sharers(sharers_o), .sharers_nxt(sh_nxt), .last_sender(last_sender_o),
      .first_t(first_time_o), .req_q_o(req_time_o), .fwd_q_o(fwd_time_o)
   );

   mat_trigger u_trig (
      .clk(clk), .rst_n(rst_n), .clr(dealloc_i), .load(alloc_i),
      .hit(hit_zero), .sh_nxt(sh_nxt), .done(done_o), .done_kind(done_shared_o)
   );

   assign active_o = active_q;
endmodule

// File: rtl/mat_chk.sv
module mat_chk #(
   parameter int NUM_CACHES = 4,
   parameter int TIME_W     = 16,
   parameter int CNT_W      = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    alloc_i,
   input logic                    dealloc_i,
   input logic                    active_o,
   input logic signed [CNT_W-1:0] pending_o,
   input logic                    err_o,
   input logic                    sharers_o,
   input logic                    done_o,
   input logic [TIME_W-1:0]       first_time_o
);
   // R2
   preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i && !dealloc_i |=> pending_o == CNT_W'(NUM_CACHES) && active_o && !err_o && !sharers_o);

   // R5
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !alloc_i && !dealloc_i |=> !done_o);

   // R5
   done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> pending_o == 0);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !alloc_i && !dealloc_i |=> err_o);

   // R4
   sharers_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sharers_o && !alloc_i && !dealloc_i |=> sharers_o);

   // R9
   first_time_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_time_o != '0 && !alloc_i && !dealloc_i |=> $stable(first_time_o));

   // R10
   wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dealloc_i |=> !active_o && pending_o == 0 && !err_o && !done_o && !sharers_o);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o && !alloc_i && !dealloc_i |=> $stable(pending_o) && !done_o);
endmodule

bind miss_ack_tracker mat_chk #(.NUM_CACHES(NUM_CACHES), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .dealloc_i(dealloc_i),
   .active_o(active_o), .pending_o(pending_o), .err_o(err_o), .sharers_o(sharers_o),
   .done_o(done_o), .first_time_o(first_time_o)
);

// File: tb/miss_ack_tracker_bench.sv
module miss_ack_tracker_bench;
   localparam int N      = 4;
   localparam int ACK_W  = 3;
   localparam int ID_W   = 4;
   localparam int TIME_W = 16;
   localparam int CNT_W  = $clog2(2 * N) + 2;
   localparam int CMAX   = (1 << (CNT_W - 1)) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_i = 0, dealloc_i = 0, rsp_valid_i = 0, rsp_shared_i = 0;
   logic dec_one_i = 0, inc_one_i = 0;
   logic [ACK_W-1:0]  rsp_acks_i = '0;
   logic [ID_W-1:0]   rsp_sender_i = '0;
   logic [TIME_W-1:0] rsp_req_time_i = '0, rsp_fwd_time_i = '0, now_i = '0;
   logic active_o, err_o, sharers_o, done_o, done_shared_o;
   logic signed [CNT_W-1:0] pending_o;
   logic [ID_W-1:0] last_sender_o;
   logic [TIME_W-1:0] first_time_o, req_time_o, fwd_time_o;

   int total = 0, bad = 0;
   // bench model of the requirements
   int m_act, m_cnt, m_sh, m_fired, m_err, m_last, m_first, m_req, m_fwd, m_done, m_kind;

   always #2 clk = ~clk;

   miss_ack_tracker #(.NUM_CACHES(N), .ACK_W(ACK_W), .ID_W(ID_W), .TIME_W(TIME_W)) u_miss_ack_tracker (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .dealloc_i(dealloc_i),
      .rsp_valid_i(rsp_valid_i), .rsp_acks_i(rsp_acks_i), .rsp_shared_i(rsp_shared_i),
      .rsp_sender_i(rsp_sender_i), .rsp_req_time_i(rsp_req_time_i),
      .rsp_fwd_time_i(rsp_fwd_time_i), .now_i(now_i), .dec_one_i(dec_one_i),
      .inc_one_i(inc_one_i), .active_o(active_o), .pending_o(pending_o), .err_o(err_o),
      .sharers_o(sharers_o), .done_o(done_o), .done_shared_o(done_shared_o),
      .last_sender_o(last_sender_o), .first_time_o(first_time_o),
      .req_time_o(req_time_o), .fwd_time_o(fwd_time_o)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic chk_all(input string rq);
      chk(rq, "active", int'(active_o), m_act);
      chk(rq, "pending", int'($signed(pending_o)), m_cnt);
      chk(rq, "err", int'(err_o), m_err);
      chk(rq, "sharers", int'(sharers_o), m_sh);
      chk(rq, "done", int'(done_o), m_done);
      if (m_done != 0) chk(rq, "done_kind", int'(done_shared_o), m_kind);
      chk(rq, "last_sender", int'(last_sender_o), m_last);
      chk(rq, "first_time", int'(first_time_o), m_first);
      chk(rq, "req_time", int'(req_time_o), m_req);
      chk(rq, "fwd_time", int'(fwd_time_o), m_fwd);
   endtask

   task automatic clear_model();
      m_act = 0; m_cnt = 0; m_sh = 0; m_fired = 0; m_err = 0; m_last = 0;
      m_first = 0; m_req = 0; m_fwd = 0; m_done = 0; m_kind = 0;
   endtask

   task automatic step(input string rq, input bit al, input bit de, input bit rv,
                       input int acks, input bit sh, input int snd, input int rt,
                       input int ft, input int nw, input bit dc, input bit ic);
      int nxt;
      bit upd;
      @(negedge clk);
      alloc_i = al; dealloc_i = de; rsp_valid_i = rv; rsp_acks_i = ACK_W'(acks);
      rsp_shared_i = sh; rsp_sender_i = ID_W'(snd); rsp_req_time_i = TIME_W'(rt);
      rsp_fwd_time_i = TIME_W'(ft); now_i = TIME_W'(nw); dec_one_i = dc; inc_one_i = ic;
      @(posedge clk);
      m_done = 0;
      if (de) clear_model();
      else if (al) begin
         clear_model();
         m_act = 1; m_cnt = N;
      end else if (m_act != 0) begin
         upd = rv | dc | ic;
         nxt = m_cnt - (rv ? acks : 0) - int'(dc) + int'(ic);
         if (upd) begin
            if (rv && acks == 0) m_err = 1;
            if (nxt < 0 || nxt > CMAX) m_err = 1;
            else m_cnt = nxt;
         end
         if (rv) begin
            if (sh) m_sh = 1;
            m_last = snd;
            if (rt != 0) m_req = rt;
            if (ft != 0) m_fwd = ft;
            if (m_first == 0) m_first = nw;
         end
         if (upd && nxt == 0 && m_fired == 0) begin
            m_fired = 1; m_done = 1; m_kind = m_sh;
         end
      end
      #1;
      chk_all(rq);
   endtask

   task automatic do_alloc(input string rq);
      step(rq, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic do_rsp(input string rq, input int acks, input bit sh, input int snd,
                         input int rt, input int ft, input int nw);
      step(rq, 0, 0, 1, acks, sh, snd, rt, ft, nw, 0, 0);
   endtask
   task automatic do_adj(input string rq, input bit dc, input bit ic);
      step(rq, 0, 0, 0, 0, 0, 0, 0, 0, 0, dc, ic);
   endtask
   task automatic do_idle(input string rq);
      step(rq, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk_all("R1");

      // R11 inactive tracker ignores responses and adjust pulses
      do_rsp("R11", 3, 1, 5, 7, 8, 9);
      do_adj("R11", 0, 1);
      do_adj("R11", 1, 0);

      // R3 R4 R5 R8: every two-way split of the owed count, with and without a sharer
      for (int a = 1; a <= N; a++) begin
         for (int s = 0; s < 2; s++) begin
            do_alloc("R2");
            do_rsp("R3", a, bit'(s), a, 0, 0, 10 + a);
            if (a < N) do_rsp("R5", N - a, 0, a + 7, 0, 0, 20);
            do_idle("R5");
         end
      end

      // R6: pulses alone, together, and alongside a response
      for (int dc = 0; dc < 2; dc++) begin
         for (int ic = 0; ic < 2; ic++) begin
            do_alloc("R2");
            step("R6", 0, 0, 1, 2, 0, 3, 0, 0, 5, bit'(dc), bit'(ic));
            do_adj("R6", 1, 0);
            do_rsp("R6", 1 + ic - dc, 1, 4, 0, 0, 6);
            do_idle("R6");
         end
      end

      // R5: after completion the count returns to zero without a second pulse
      do_alloc("R2");
      do_rsp("R5", N, 0, 1, 0, 0, 3);
      do_adj("R5", 0, 1);
      do_adj("R5", 1, 0);
      do_idle("R5");

      // R7 underflow holds the count and sets err; err stays set
      do_alloc("R2");
      do_rsp("R7", 7, 0, 2, 0, 0, 4);
      do_adj("R7", 1, 0);
      // R7 overflow at the top of the range
      do_alloc("R2");
      for (int k = 0; k < CMAX - N + 1; k++) do_adj("R7", 0, 1);

      // R3 zero-ack response flags an error
      do_alloc("R2");
      do_rsp("R3", 0, 0, 6, 0, 0, 2);

      // R9 timestamp capture and adoption
      do_alloc("R2");
      do_rsp("R9", 1, 0, 1, 0, 0, 0);
      do_rsp("R9", 1, 0, 2, 33, 0, 40);
      do_rsp("R9", 1, 0, 3, 0, 44, 50);
      do_rsp("R8", 1, 0, 9, 55, 0, 60);

      // R10 dealloc wipes; dealloc wins over a simultaneous alloc
      step("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_alloc("R2");
      do_rsp("R4", 1, 1, 4, 12, 13, 14);
      step("R10", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_rsp("R11", 2, 0, 1, 0, 0, 1);

      @(negedge clk);
      rsp_valid_i = 0; alloc_i = 0; dealloc_i = 0; dec_one_i = 0; inc_one_i = 0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule